// File: doc/BRIEF.md
# Burst Address Generator with Selectable Beat Order

This block produces the word address for a synchronous burst memory. A base address from outside is captured when either of two load strobes is asserted. One strobe comes from the processor side and counts only while a qualify input is high. The other comes from the memory controller and is not qualified. After a load, the low `CNT_W` address bits follow a burst sequence whose beat counter moves one step on every cycle in which the advance input is high. The upper bits keep the loaded value until the next load.

Two beat orders are supported. Linear order adds the beat count to the loaded low bits and wraps inside the aligned block. Interleaved order XORs the loaded low bits with the beat count. The order is taken from an order-select input at load time, or from a parameter when the input is not used. An unused order input gives interleaved order by default. A load may occur on every cycle, so the block also works as a plain registered address path when bursts are not used.

Top module: `bag_burst_addr_gen`

## Requirements
- R1: While and after reset with no strobe or advance, `addr` is all zeros, `beat` is 0 and `burst_last` is 0.
- R2: When `strobe_ctl` is high at a clock edge, whatever `cs_ok` is, `addr` equals the `ext_addr` sampled at that edge and `beat` is 0 from the next cycle on.
- R3: `strobe_cpu` loads the address in the same way as `strobe_ctl`, but only when `cs_ok` is high. With `cs_ok` low it is ignored and `addr` and `beat` keep their values.
- R4: On an advance with no load, `beat` increments modulo 4 (modulo 2^CNT_W) and the upper address bits `addr[ADDR_W-1:CNT_W]` do not change.
- R5: In linear order (`order_lin`=1 at the load), `addr[CNT_W-1:0]` equals the loaded low bits plus `beat`, modulo 2^CNT_W. A start of 2 gives 2,3,0,1.
- R6: In interleaved order (`order_lin`=0 at the load), `addr[CNT_W-1:0]` equals the loaded low bits XOR `beat`. A start of 1 gives 1,0,3,2.
- R7: A load and an advance in the same cycle act as a load alone: the new address with `beat` 0.
- R8: With no qualified load and no advance, `addr` and `beat` hold their values.
- R9: The order is captured at the load. A change on `order_lin` during a burst has no effect until the next load.
- R10: Loads on consecutive cycles with the advance never asserted put each sampled `ext_addr` on `addr` in the following cycle.
- R11: `burst_last` is high exactly when `beat` is at its final value (3 for a four-beat burst). An advance from that value wraps `beat` to 0.
- R12: With `ORDER_PIN_EN`=0, `order_lin` is ignored and the order comes from `DEFAULT_LINEAR`. The default value 0 selects interleaved order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_ok | input | 1 | Qualify for the processor-side strobe |
| strobe_cpu | input | 1 | Processor-side load strobe, gated by `cs_ok` |
| strobe_ctl | input | 1 | Controller-side load strobe, not gated |
| adv | input | 1 | Advance the burst by one beat |
| order_lin | input | 1 | 1 = linear order, 0 = interleaved order; sampled at load |
| ext_addr | input | ADDR_W | External base address |
| addr | output | ADDR_W | Current word address |
| beat | output | CNT_W | Beats advanced since the last load |
| burst_last | output | 1 | High on the final beat of the block |

## Verification
The hardest case to reach from the ports is a change on `order_lin` in the middle of a burst combined with advances that wrap past the last beat. Random stimulus rarely keeps the strobes quiet for long enough while the order input toggles. Directed sequences therefore load a base, flip the order input, and advance through and past the wrap. A fixed-seed random phase with a reduced load probability then mixes gated processor strobes, loads that coincide with advances, and long advance runs. A second instance with the order input disabled receives the same stimulus, so its fixed interleaved order is checked on every cycle.

// File: rtl/bag_pkg.sv
`timescale 1ns/1ps
package bag_pkg;

   typedef enum logic [1:0] {
      OP_HOLD = 2'd0,
      OP_LOAD = 2'd1,
      OP_STEP = 2'd2
   } bag_op_e;

   typedef enum logic {
      ORD_INTERLEAVE = 1'b0,
      ORD_LINEAR     = 1'b1
   } bag_order_e;

endpackage

// File: rtl/bag_strobe_ctrl.sv
`timescale 1ns/1ps
module bag_strobe_ctrl
   import bag_pkg::*;
(
   input  logic    cs_ok,
   input  logic    strobe_cpu,
   input  logic    strobe_ctl,
   input  logic    adv,
   output bag_op_e op
);

   logic cpu_load;
   logic any_load;

   assign cpu_load = strobe_cpu & cs_ok;
   assign any_load = cpu_load | strobe_ctl;

   // A load outranks an advance in the same cycle.
   always_comb begin
      if (any_load)  op = OP_LOAD;
      else if (adv)  op = OP_STEP;
      else           op = OP_HOLD;
   end

endmodule

// File: rtl/bag_beat_unit.sv
`timescale 1ns/1ps
module bag_beat_unit
   import bag_pkg::*;
#(
   parameter int CNT_W          = 2,
   parameter bit ORDER_PIN_EN   = 1'b1,
   parameter bit DEFAULT_LINEAR = 1'b0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  bag_op_e          op,
   input  logic [CNT_W-1:0] load_low,
   input  logic             order_pin,
   output logic [CNT_W-1:0] low_out,
   output logic [CNT_W-1:0] beat_out,
   output logic             last_out
);

   localparam bag_order_e ORD_DEF = DEFAULT_LINEAR ? ORD_LINEAR : ORD_INTERLEAVE;
   localparam logic [CNT_W-1:0] BEAT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] base_q;
   logic [CNT_W-1:0] beat_q;
   bag_order_e       ord_q;
   bag_order_e       ord_src;

   generate
      if (ORDER_PIN_EN) begin : g_order_pin
         assign ord_src = bag_order_e'(order_pin);
      end else begin : g_order_fixed
         logic order_pin_unused;
         assign order_pin_unused = order_pin;
         assign ord_src = ORD_DEF;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         beat_q <= '0;
         ord_q  <= ORD_DEF;
      end else begin
         case (op)
            OP_LOAD: begin
               base_q <= load_low;
               beat_q <= '0;
               ord_q  <= ord_src;
            end
            OP_STEP: beat_q <= beat_q + BEAT_ONE;
            default: ;
         endcase
      end
   end

   always_comb begin
      if (ord_q == ORD_LINEAR) low_out = base_q + beat_q;
      else                     low_out = base_q ^ beat_q;
   end

   assign beat_out = beat_q;
   assign last_out = &beat_q;

   // R9: the captured order changes only on a load
   p_order_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (op != OP_LOAD) |=> (ord_q == $past(ord_q)));

   // R11: stepping from the last beat wraps to zero
   p_step_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_STEP && last_out) |=> (beat_q == '0));

   // R4: base bits are untouched by a step
   p_base_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_STEP) |=> $stable(base_q));

endmodule

// File: rtl/bag_upper_reg.sv
`timescale 1ns/1ps
module bag_upper_reg
   import bag_pkg::*;
#(
   parameter int UP_W = 18
)(
   input  logic            clk,
   input  logic            rst_n,
   input  bag_op_e         op,
   input  logic [UP_W-1:0] d,
   output logic [UP_W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n)             q <= '0;
      else if (op == OP_LOAD) q <= d;
   end

endmodule

// File: rtl/bag_burst_addr_gen.sv
`timescale 1ns/1ps
module bag_burst_addr_gen
   import bag_pkg::*;
#(
   parameter int ADDR_W         = 20,
   parameter int CNT_W          = 2,
   parameter bit ORDER_PIN_EN   = 1'b1,
   parameter bit DEFAULT_LINEAR = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_ok,
   input  logic              strobe_cpu,
   input  logic              strobe_ctl,
   input  logic              adv,
   input  logic              order_lin,
   input  logic [ADDR_W-1:0] ext_addr,
   output logic [ADDR_W-1:0] addr,
   output logic [CNT_W-1:0]  beat,
   output logic              burst_last
);

   localparam int UP_W = ADDR_W - CNT_W;

   generate
      if (CNT_W < 1) begin : g_chk_cnt
         $error("CNT_W must be at least 1");
      end
      if (UP_W < 1) begin : g_chk_up
         $error("ADDR_W must exceed CNT_W");
      end
   endgenerate

   bag_op_e          op;
   logic [UP_W-1:0]  upper_q;
   logic [CNT_W-1:0] low_w;

   bag_strobe_ctrl u_ctrl (
      .cs_ok      (cs_ok),
      .strobe_cpu (strobe_cpu),
      .strobe_ctl (strobe_ctl),
      .adv        (adv),
      .op         (op)
   );

   bag_beat_unit #(
      .CNT_W          (CNT_W),
      .ORDER_PIN_EN   (ORDER_PIN_EN),
      .DEFAULT_LINEAR (DEFAULT_LINEAR)
   ) u_beat (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .load_low  (ext_addr[CNT_W-1:0]),
      .order_pin (order_lin),
      .low_out   (low_w),
      .beat_out  (beat),
      .last_out  (burst_last)
   );

   bag_upper_reg #(
      .UP_W (UP_W)
   ) u_upper (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (op),
      .d     (ext_addr[ADDR_W-1:CNT_W]),
      .q     (upper_q)
   );

   assign addr = {upper_q, low_w};

   // R2: controller strobe loads regardless of qualify
   p_ctl_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_ctl |=> (addr == $past(ext_addr)) && (beat == '0));

   // R3: qualified processor strobe loads
   p_cpu_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_cpu && cs_ok) |=> (addr == $past(ext_addr)) && (beat == '0));

   // R3: unqualified processor strobe has no effect
   p_cpu_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_cpu && !cs_ok && !strobe_ctl && !adv) |=> $stable(addr) && $stable(beat));

   // R8: idle cycle holds everything
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe_ctl && !(strobe_cpu && cs_ok) && !adv) |=> $stable(addr) && $stable(beat));

   // R4: advance steps beat and keeps the upper bits
   p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !strobe_ctl && !(strobe_cpu && cs_ok)) |=>
         (addr[ADDR_W-1:CNT_W] == $past(addr[ADDR_W-1:CNT_W])) &&
         (beat == CNT_W'($past(beat) + 1'b1)));

endmodule

// File: tb/tb_bag_burst_addr_gen.sv
`timescale 1ns/1ps
module tb_bag_burst_addr_gen;

   localparam int AW = 20;
   localparam int CW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs_ok = 1'b0, strobe_cpu = 1'b0, strobe_ctl = 1'b0, adv = 1'b0, order_lin = 1'b0;
   logic [AW-1:0] ext_addr = '0;
   logic [AW-1:0] addr, addr_fx;
   logic [CW-1:0] beat, beat_fx;
   logic          burst_last, last_fx;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   // model state
   logic [AW-CW-1:0] m_up = '0;
   logic [CW-1:0]    m_base = '0, m_beat = '0;
   logic             m_lin = 1'b0;

   always #2 clk = ~clk;

   bag_burst_addr_gen dut (
      .clk(clk), .rst_n(rst_n), .cs_ok(cs_ok), .strobe_cpu(strobe_cpu),
      .strobe_ctl(strobe_ctl), .adv(adv), .order_lin(order_lin),
      .ext_addr(ext_addr), .addr(addr), .beat(beat), .burst_last(burst_last));

   bag_burst_addr_gen #(.ORDER_PIN_EN(1'b0)) dut_fixed (
      .clk(clk), .rst_n(rst_n), .cs_ok(cs_ok), .strobe_cpu(strobe_cpu),
      .strobe_ctl(strobe_ctl), .adv(adv), .order_lin(order_lin),
      .ext_addr(ext_addr), .addr(addr_fx), .beat(beat_fx), .burst_last(last_fx));

   function automatic logic [AW-1:0] exp_addr(input logic lin);
      logic [CW-1:0] lo;
      lo = lin ? (m_base + m_beat) : (m_base ^ m_beat);
      return {m_up, lo};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      chk(tag, 32'(addr), 32'(exp_addr(m_lin)));
      chk(tag, 32'(beat), 32'(m_beat));
      chk("R11", 32'(burst_last), 32'(m_beat == 2'd3));
      chk("R12", 32'(addr_fx), 32'(exp_addr(1'b0)));
   endtask

   // drive one cycle, update the model at the edge, check 1 ns later
   task automatic cyc(input logic ctl, input logic cpu, input logic cs,
                      input logic a, input logic ord, input logic [AW-1:0] ea,
                      input string tag);
      logic ld;
      strobe_ctl = ctl; strobe_cpu = cpu; cs_ok = cs; adv = a;
      order_lin = ord; ext_addr = ea;
      @(posedge clk);
      ld = ctl | (cpu & cs);
      if (ld) begin
         m_up = ea[AW-1:CW]; m_base = ea[CW-1:0]; m_beat = '0; m_lin = ord;
      end else if (a) begin
         m_beat = m_beat + 2'd1;
      end
      #1;
      check_all(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] prev;
      repeat (4) @(posedge clk);
      #1;
      check_all("R1");
      rst_n = 1'b1;
      cyc(0,0,0,0,0, '0, "R1");
      chk("R1", 32'(addr), 32'h0);
      chk("R1", 32'(burst_last), 32'h0);

      // R2: controller strobe with qualify low
      cyc(1,0,0,0,0, 20'hABCD5, "R2");
      chk("R2", 32'(addr), 32'hABCD5);

      // R6: interleaved from 1 -> 1,0,3,2
      cyc(1,0,0,0,0, 20'h12341, "R6");
      chk("R6", 32'(addr[1:0]), 32'd1);
      cyc(0,0,0,1,0, '0, "R6"); chk("R6", 32'(addr[1:0]), 32'd0);
      cyc(0,0,0,1,0, '0, "R6"); chk("R6", 32'(addr[1:0]), 32'd3);
      cyc(0,0,0,1,0, '0, "R6"); chk("R6", 32'(addr[1:0]), 32'd2);
      chk("R11", 32'(burst_last), 32'd1);
      cyc(0,0,0,1,0, '0, "R11"); chk("R11", 32'(beat), 32'd0);
      chk("R4", 32'(addr[AW-1:CW]), 32'(20'h12341 >> 2));

      // R5: linear from 2 -> 2,3,0,1 and upper bits kept (R4)
      cyc(0,1,1,0,1, 20'h0FFF2, "R5");
      chk("R5", 32'(addr[1:0]), 32'd2);
      cyc(0,0,0,1,1, '0, "R5"); chk("R5", 32'(addr[1:0]), 32'd3);
      cyc(0,0,0,1,1, '0, "R5"); chk("R5", 32'(addr[1:0]), 32'd0);
      chk("R4", 32'(addr[AW-1:CW]), 32'(20'h0FFF2 >> 2));
      cyc(0,0,0,1,1, '0, "R5"); chk("R5", 32'(addr[1:0]), 32'd1);

      // R3: unqualified processor strobe ignored, then qualified loads
      prev = addr;
      cyc(0,1,0,0,0, 20'h55555, "R3");
      chk("R3", 32'(addr), 32'(prev));
      cyc(0,1,1,0,0, 20'h55555, "R3");
      chk("R3", 32'(addr), 32'h55555);

      // R8: idle holds
      cyc(0,0,0,1,0, '0, "R4");
      prev = addr;
      cyc(0,0,1,0,1, 20'hFFFFF, "R8");
      chk("R8", 32'(addr), 32'(prev));

      // R7: load wins over advance
      cyc(1,0,0,1,0, 20'h3C3C2, "R7");
      chk("R7", 32'(addr), 32'h3C3C2);
      chk("R7", 32'(beat), 32'd0);

      // R9: order captured at load; pin flip mid-burst ignored
      cyc(1,0,0,0,1, 20'h00001, "R9");
      cyc(0,0,0,1,0, '0, "R9"); chk("R9", 32'(addr[1:0]), 32'd2);
      cyc(0,0,0,1,0, '0, "R9"); chk("R9", 32'(addr[1:0]), 32'd3);
      // R12: fixed-order instance stayed interleaved: 1^2 = 3
      chk("R12", 32'(addr_fx[1:0]), 32'd3);

      // R10: back-to-back loads, no advance
      for (int i = 0; i < 8; i++) begin
         logic [AW-1:0] ea;
         ea = AW'(32'h9E377 * (i + 1));
         cyc(i[0], ~i[0], 1, 0, i[1], ea, "R10");
         chk("R10", 32'(addr), 32'(ea));
      end

      // random phase, fixed seed
      void'($urandom(32'd4242));
      for (int i = 0; i < 4000; i++) begin
         logic c, p, q, a, o;
         logic [AW-1:0] ea;
         string tg;
         c  = ($urandom % 8) == 0;
         p  = ($urandom % 6) == 0;
         q  = $urandom % 2;
         a  = ($urandom % 4) != 0;
         o  = ($urandom % 5) == 0 ? ~order_lin : order_lin;
         ea = AW'($urandom);
         if ((c | (p & q)) && a) tg = "R7";
         else if (c)             tg = "R2";
         else if (p & q)         tg = "R3";
         else if (a)             tg = m_lin ? "R5" : "R6";
         else                    tg = "R8";
         cyc(c, p, q, a, o, ea, tg);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule